// File: doc/BRIEF.md
# Grouped Pre-image Consistency Filter

This block narrows the key candidates that survive a differential fault analysis. For each of sixteen 4-bit key positions, it receives a set of surviving candidates. Each candidate carries the 4-bit output difference it predicts. The positions form four groups of four. All four equations in a group derive from one shared 4-bit fault image, and in each equation one known bit of that image has been forced to zero. A predicted difference t at a position whose forced bit is j can therefore come from two images: t itself, or t with bit j set.

The filter takes one group per clock. It builds the image set of every position as a 16-bit bitmap and intersects the four bitmaps. It keeps only those common images that every position in the group can explain with a surviving candidate. It then removes any candidate whose difference has no valid image. The pruned key masks are ANDed into an accumulated mask bank, so results from successive fault pairs narrow the space step by step.

After the last group of an observation, the block walks the sixteen masks and multiplies their popcounts into a candidate-count estimate. It compares that estimate against a threshold so that software knows when to stop collecting faults. A clear input starts a new attack run.

Top module: `grp_consistency_filter`

## Requirements
- R1: For each position, the image set is the union over surviving candidates of {t, t | (1 << j)}, where t is the candidate's 4-bit difference and j is the position's forced bit. The group's common set is the intersection of its four image sets. A candidate whose two images both lie outside the common set is removed.
- R2: A common image g is valid only if every position n in the group has a surviving candidate with difference equal to g with bit j_n cleared. A candidate whose images are all invalid is removed, even if one of them is in the common set.
- R3: A group beat carries, for local position q (0..3), a keep mask in `grp_keep[16q +: 16]`, where bit k marks key candidate k. It carries the difference of candidate k in `grp_diff[64q + 4k +: 4]` and the forced bit in `grp_jsel[2q +: 2]`. The group maps to global positions 4m+q, where m = `grp_idx`.
- R4: An accepted beat ANDs the pruned masks into the accumulated masks of its group on that clock edge. `out_mask[16p +: 16]` holds position p. Bits are never added except by reset or clear.
- R5: Accepting a beat with `grp_idx` = 3 starts a scan that keeps `busy` high. After the scan, `result_valid` pulses for one cycle. At that point `count_est` holds the product of the sixteen mask popcounts, capped at 2^64.
- R6: `below_threshold` is set with the result exactly when `count_est` < `threshold`. The comparison is strict.
- R7: `empty_error` is set with the result exactly when some accumulated mask is empty. `count_est` is then zero.
- R8: `clear` sets every mask to all ones, aborts a scan, and zeroes `count_est`, `below_threshold` and `empty_error`. A beat arriving in the same cycle as `clear` is dropped.
- R9: A beat presented while `busy` is high is ignored and leaves the masks unchanged.
- R10: After reset, the masks are all ones, and `busy`, `result_valid`, `below_threshold` and `empty_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Start a new attack run |
| grp_valid | input | 1 | Group beat present |
| grp_idx | input | 2 | Group number m |
| grp_keep | input | 64 | Four 16-bit survivor key masks |
| grp_diff | input | 256 | Sixteen 4-bit differences per local position |
| grp_jsel | input | 8 | Forced-zero bit index per local position |
| threshold | input | 64 | Stop threshold for the count estimate |
| out_mask | output | 256 | Accumulated key masks, 16 bits per position |
| busy | output | 1 | Count scan in progress |
| result_valid | output | 1 | One-cycle pulse when a count is ready |
| count_est | output | 65 | Product of mask popcounts, capped at 2^64 |
| below_threshold | output | 1 | Count below threshold |
| empty_error | output | 1 | Some position has no candidate left |

## Verification
The hardest case to reach from the ports is a common image that every image set contains but that one position cannot explain, because random stimulus almost never produces it. The stimulus builds one group by hand. In that group, image 7 lies in all four sets, but position 0 lacks the difference 6 that the validity test needs. Image 3 is valid. The bench then checks that only the candidates explained by 3 survive. A second hard case is a beat arriving during a scan. The bench injects an all-zero beat right after the last group, while `busy` is high, and checks that the masks and the count it would have destroyed are unchanged.

// File: rtl/gcf_pkg.sv
package gcf_pkg;

  typedef enum logic {
    CU_IDLE = 1'b0,
    CU_SCAN = 1'b1
  } cu_state_e;

  function automatic int unsigned pop64(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += 32'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/gcf_preimage_map.sv
// Builds, for one position, the bitmap of surviving differences and the
// bitmap of their possible images (difference with / without forced bit).
module gcf_preimage_map #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned NV  = 1 << NIB_W,
  localparam int unsigned J_W = $clog2(NIB_W)
) (
  input  logic [NV-1:0]       keep,
  input  logic [NV*NIB_W-1:0] diff,
  input  logic [J_W-1:0]      jsel,
  output logic [NV-1:0]       pre_set,
  output logic [NV-1:0]       diff_set
);

  always_comb begin
    logic [NIB_W-1:0] t;
    logic [NIB_W-1:0] tj;
    pre_set  = '0;
    diff_set = '0;
    for (int k = 0; k < NV; k++) begin
      t  = diff[k*NIB_W +: NIB_W];
      tj = t | (NIB_W'(1) << jsel);
      if (keep[k]) begin
        diff_set[t] = 1'b1;
        pre_set[t]  = 1'b1;
        pre_set[tj] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gcf_group_prune.sv
// Joint filtering of one group: intersect image sets, validate each
// common image against every position, drop unexplained candidates.
module gcf_group_prune #(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned GRP_SIZE = 4,
  localparam int unsigned NV  = 1 << NIB_W,
  localparam int unsigned J_W = $clog2(NIB_W)
) (
  input  logic [GRP_SIZE*NV-1:0]       keep,
  input  logic [GRP_SIZE*NV*NIB_W-1:0] diff,
  input  logic [GRP_SIZE*J_W-1:0]      jsel,
  output logic [GRP_SIZE*NV-1:0]       keep_out
);

  logic [NV-1:0] pre_set  [GRP_SIZE];
  logic [NV-1:0] diff_set [GRP_SIZE];
  logic [NV-1:0] common;
  logic [NV-1:0] valid_img;

  for (genvar q = 0; q < GRP_SIZE; q++) begin : g_pos
    gcf_preimage_map #(.NIB_W(NIB_W)) u_map (
      .keep     (keep[q*NV +: NV]),
      .diff     (diff[q*NV*NIB_W +: NV*NIB_W]),
      .jsel     (jsel[q*J_W +: J_W]),
      .pre_set  (pre_set[q]),
      .diff_set (diff_set[q])
    );
  end

  always_comb begin
    common = '1;
    for (int q = 0; q < GRP_SIZE; q++) common &= pre_set[q];
  end

  always_comb begin
    logic             ok;
    logic [NIB_W-1:0] gc;
    for (int g = 0; g < NV; g++) begin
      ok = common[g];
      for (int q = 0; q < GRP_SIZE; q++) begin
        gc = NIB_W'(g) & ~(NIB_W'(1) << jsel[q*J_W +: J_W]);
        ok = ok & diff_set[q][gc];
      end
      valid_img[g] = ok;
    end
  end

  always_comb begin
    logic [NIB_W-1:0] t;
    logic [NIB_W-1:0] tj;
    for (int q = 0; q < GRP_SIZE; q++) begin
      for (int k = 0; k < NV; k++) begin
        t  = diff[(q*NV + k)*NIB_W +: NIB_W];
        tj = t | (NIB_W'(1) << jsel[q*J_W +: J_W]);
        keep_out[q*NV + k] = keep[q*NV + k] & (valid_img[t] | valid_img[tj]);
      end
    end
  end

endmodule

// File: rtl/gcf_mask_bank.sv
// Accumulated survivor masks, one row per group; AND-update on write.
module gcf_mask_bank #(
  parameter int unsigned NV       = 16,
  parameter int unsigned GRP_SIZE = 4,
  parameter int unsigned NUM_GRP  = 4,
  localparam int unsigned ROW_W = GRP_SIZE * NV,
  localparam int unsigned NPOS  = GRP_SIZE * NUM_GRP,
  localparam int unsigned GI_W  = $clog2(NUM_GRP),
  localparam int unsigned PI_W  = $clog2(NPOS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 wr_en,
  input  logic [GI_W-1:0]      wr_grp,
  input  logic [ROW_W-1:0]     wr_keep,
  input  logic [PI_W-1:0]      rd_idx,
  output logic [NV-1:0]        rd_data,
  output logic [NPOS*NV-1:0]   all_mask
);

  for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_row
    logic [ROW_W-1:0] row;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        row <= '1;
      end else if (wr_en && (wr_grp == GI_W'(gi))) begin
        row <= row & wr_keep;
      end
    end
    assign all_mask[gi*ROW_W +: ROW_W] = row;
  end

  assign rd_data = all_mask[rd_idx*NV +: NV];

endmodule

// File: rtl/gcf_count_unit.sv
// Sequential popcount product over all positions with saturation,
// threshold compare and empty detection.
module gcf_count_unit
  import gcf_pkg::*;
#(
  parameter int unsigned NV    = 16,
  parameter int unsigned NPOS  = 16,
  parameter int unsigned CNT_W = 64,
  localparam int unsigned PI_W = $clog2(NPOS),
  localparam int unsigned PC_W = $clog2(NV + 1),
  localparam int unsigned PR_W = CNT_W + 1 + PC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start,
  input  logic [NV-1:0]    rd_data,
  input  logic [CNT_W-1:0] threshold,
  output logic [PI_W-1:0]  rd_idx,
  output logic             busy,
  output logic             result_valid,
  output logic [CNT_W:0]   count_est,
  output logic             below_threshold,
  output logic             empty_error
);

  localparam logic [CNT_W:0] CAP = {1'b1, {CNT_W{1'b0}}};

  cu_state_e        state;
  logic [CNT_W:0]   prod;
  logic             seen_empty;
  logic [PC_W-1:0]  pop;
  logic [PR_W-1:0]  wide;
  logic [CNT_W:0]   nxt;
  logic             pos_empty;

  always_comb begin
    pop       = PC_W'(pop64(64'(rd_data)));
    pos_empty = (pop == '0);
    wide      = PR_W'(prod) * PR_W'(pop);
    nxt       = (wide > PR_W'(CAP)) ? CAP : wide[CNT_W:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state           <= CU_IDLE;
      rd_idx          <= '0;
      prod            <= '0;
      seen_empty      <= 1'b0;
      result_valid    <= 1'b0;
      count_est       <= '0;
      below_threshold <= 1'b0;
      empty_error     <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      case (state)
        CU_IDLE: begin
          if (start) begin
            state      <= CU_SCAN;
            rd_idx     <= '0;
            prod       <= (CNT_W+1)'(1);
            seen_empty <= 1'b0;
          end
        end
        CU_SCAN: begin
          prod       <= nxt;
          seen_empty <= seen_empty | pos_empty;
          if (rd_idx == PI_W'(NPOS - 1)) begin
            state           <= CU_IDLE;
            result_valid    <= 1'b1;
            count_est       <= nxt;
            below_threshold <= (nxt < {1'b0, threshold});
            empty_error     <= seen_empty | pos_empty;
          end else begin
            rd_idx <= rd_idx + PI_W'(1);
          end
        end
        default: state <= CU_IDLE;
      endcase
    end
  end

  assign busy = (state == CU_SCAN);

endmodule

// File: rtl/grp_consistency_filter.sv
module grp_consistency_filter #(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned GRP_SIZE = 4,
  parameter int unsigned NUM_GRP  = 4,
  parameter int unsigned CNT_W    = 64,
  localparam int unsigned NV    = 1 << NIB_W,
  localparam int unsigned J_W   = $clog2(NIB_W),
  localparam int unsigned GI_W  = $clog2(NUM_GRP),
  localparam int unsigned NPOS  = GRP_SIZE * NUM_GRP,
  localparam int unsigned PI_W  = $clog2(NPOS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          grp_valid,
  input  logic [GI_W-1:0]               grp_idx,
  input  logic [GRP_SIZE*NV-1:0]        grp_keep,
  input  logic [GRP_SIZE*NV*NIB_W-1:0]  grp_diff,
  input  logic [GRP_SIZE*J_W-1:0]       grp_jsel,
  input  logic [CNT_W-1:0]              threshold,
  output logic [NPOS*NV-1:0]            out_mask,
  output logic                          busy,
  output logic                          result_valid,
  output logic [CNT_W:0]                count_est,
  output logic                          below_threshold,
  output logic                          empty_error
);

  logic                   accept;
  logic                   start;
  logic [GRP_SIZE*NV-1:0] pruned;
  logic [PI_W-1:0]        rd_idx;
  logic [NV-1:0]          rd_data;

  assign accept = grp_valid && !busy && !clear;
  assign start  = accept && (grp_idx == GI_W'(NUM_GRP - 1));

  gcf_group_prune #(.NIB_W(NIB_W), .GRP_SIZE(GRP_SIZE)) u_prune (
    .keep     (grp_keep),
    .diff     (grp_diff),
    .jsel     (grp_jsel),
    .keep_out (pruned)
  );

  gcf_mask_bank #(.NV(NV), .GRP_SIZE(GRP_SIZE), .NUM_GRP(NUM_GRP)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .wr_en    (accept),
    .wr_grp   (grp_idx),
    .wr_keep  (pruned),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .all_mask (out_mask)
  );

  gcf_count_unit #(.NV(NV), .NPOS(NPOS), .CNT_W(CNT_W)) u_count (
    .clk             (clk),
    .rst             (rst),
    .clear           (clear),
    .start           (start),
    .rd_data         (rd_data),
    .threshold       (threshold),
    .rd_idx          (rd_idx),
    .busy            (busy),
    .result_valid    (result_valid),
    .count_est       (count_est),
    .below_threshold (below_threshold),
    .empty_error     (empty_error)
  );

endmodule

// File: rtl/grp_consistency_filter_chk.sv
module grp_consistency_filter_chk #(
  parameter int unsigned MASK_W  = 256,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned GI_W    = 2,
  parameter int unsigned NUM_GRP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              clear,
  input logic              grp_valid,
  input logic [GI_W-1:0]   grp_idx,
  input logic [MASK_W-1:0] out_mask,
  input logic              busy,
  input logic              result_valid,
  input logic [CNT_W:0]    count_est,
  input logic              below_threshold,
  input logic              empty_error
);

  p_mask_shrink_r4: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ((out_mask & ~$past(out_mask)) == '0));

  p_clear_state_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (out_mask == '1 && !busy && !result_valid
               && !below_threshold && !empty_error));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !clear) |=> (out_mask == $past(out_mask)));

  p_scan_start_r5: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !busy && !clear && grp_idx == GI_W'(NUM_GRP - 1)) |=> busy);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  p_idle_result_r5: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy);

  p_empty_zero_r7: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (empty_error == (count_est == '0)));

endmodule

bind grp_consistency_filter grp_consistency_filter_chk #(
  .MASK_W(NPOS * NV), .CNT_W(CNT_W), .GI_W(GI_W), .NUM_GRP(NUM_GRP)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .clear           (clear),
  .grp_valid       (grp_valid),
  .grp_idx         (grp_idx),
  .out_mask        (out_mask),
  .busy            (busy),
  .result_valid    (result_valid),
  .count_est       (count_est),
  .below_threshold (below_threshold),
  .empty_error     (empty_error)
);

// File: tb/grp_consistency_filter_bench.sv
module grp_consistency_filter_bench;

  typedef struct packed {
    logic [255:0] mask;
    logic [64:0]  cnt;
    logic         below;
    logic         err;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clear = 1'b0;
  logic         grp_valid = 1'b0;
  logic [1:0]   grp_idx = '0;
  logic [63:0]  grp_keep = '0;
  logic [255:0] grp_diff = '0;
  logic [7:0]   grp_jsel = '0;
  logic [63:0]  threshold = '0;
  logic [255:0] out_mask;
  logic         busy;
  logic         result_valid;
  logic [64:0]  count_est;
  logic         below_threshold;
  logic         empty_error;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;

  exp_t        sb_q[$];
  logic [15:0] m_acc [16];
  logic [15:0] o_keep [16];
  logic [3:0]  o_diff [16][16];
  logic [1:0]  o_j [16];
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  grp_consistency_filter u_grp_consistency_filter (
    .clk(clk), .rst(rst), .clear(clear), .grp_valid(grp_valid),
    .grp_idx(grp_idx), .grp_keep(grp_keep), .grp_diff(grp_diff),
    .grp_jsel(grp_jsel), .threshold(threshold), .out_mask(out_mask),
    .busy(busy), .result_valid(result_valid), .count_est(count_est),
    .below_threshold(below_threshold), .empty_error(empty_error)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [255:0] model_mask();
    logic [255:0] v;
    for (int p = 0; p < 16; p++) v[p*16 +: 16] = m_acc[p];
    return v;
  endfunction

  // Reference pruning of one group per R1/R2/R3, then AND into model (R4)
  task automatic model_group(input int m);
    logic [15:0] pre [4];
    logic [15:0] ds [4];
    logic [15:0] common, vld, kept;
    logic [3:0]  t, tj, gc;
    common = '1;
    for (int q = 0; q < 4; q++) begin
      pre[q] = '0; ds[q] = '0;
      for (int k = 0; k < 16; k++) if (o_keep[4*m+q][k]) begin
        t = o_diff[4*m+q][k];
        tj = t | (4'd1 << o_j[4*m+q]);
        ds[q][t] = 1'b1; pre[q][t] = 1'b1; pre[q][tj] = 1'b1;
      end
      common &= pre[q];
    end
    for (int g = 0; g < 16; g++) begin
      vld[g] = common[g];
      for (int q = 0; q < 4; q++) begin
        gc = 4'(g) & ~(4'd1 << o_j[4*m+q]);
        vld[g] = vld[g] & ds[q][gc];
      end
    end
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k < 16; k++) begin
        t = o_diff[4*m+q][k];
        tj = t | (4'd1 << o_j[4*m+q]);
        kept[k] = o_keep[4*m+q][k] & (vld[t] | vld[tj]);
      end
      m_acc[4*m+q] = m_acc[4*m+q] & kept;
    end
  endtask

  task automatic send_obs(input logic [63:0] thr);
    exp_t        e;
    logic [127:0] p;
    int unsigned  pc;
    while (busy) @(negedge clk);
    threshold = thr;
    for (int m = 0; m < 4; m++) model_group(m);
    p = 128'd1;
    e.err = 1'b0;
    for (int pos = 0; pos < 16; pos++) begin
      pc = $countones(m_acc[pos]);
      if (pc == 0) e.err = 1'b1;
      p = p * 128'(pc);
      if (p > (128'd1 << 64)) p = 128'd1 << 64;
    end
    e.cnt   = p[64:0];
    e.below = (p < {64'd0, thr});
    e.mask  = model_mask();
    sb_q.push_back(e);
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      grp_valid = 1'b1;
      grp_idx   = 2'(m);
      for (int q = 0; q < 4; q++) begin
        grp_keep[q*16 +: 16] = o_keep[4*m+q];
        grp_jsel[q*2 +: 2]   = o_j[4*m+q];
        for (int k = 0; k < 16; k++) grp_diff[(q*16+k)*4 +: 4] = o_diff[4*m+q][k];
      end
    end
    @(negedge clk);
    grp_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    for (int p = 0; p < 16; p++) m_acc[p] = '1;
    chk(out_mask == '1 && !busy && !below_threshold && !empty_error && count_est == '0,
        "R8 clear state", 128'(out_mask[15:0]), 128'hffff);
  endtask

  task automatic wait_idle();
    while (busy || sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill_full();
    for (int p = 0; p < 16; p++) begin
      o_keep[p] = '1; o_j[p] = 2'(p % 4);
      for (int k = 0; k < 16; k++) o_diff[p][k] = 4'(k);
    end
  endtask

  task automatic fill_rand();
    for (int p = 0; p < 16; p++) begin
      rng = nxt_rng(rng); o_keep[p] = rng[15:0] | 16'h0101; o_j[p] = rng[17:16];
      for (int k = 0; k < 16; k++) begin
        rng = nxt_rng(rng); o_diff[p][k] = rng[7:4];
      end
    end
  endtask

  task automatic fill_pair();
    for (int p = 0; p < 16; p++) begin
      o_keep[p] = 16'h0003; o_j[p] = 2'(p % 4);
      for (int k = 0; k < 16; k++) o_diff[p][k] = 4'd0;
    end
  endtask

  // Monitor: pops expected items and compares as results appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (result_valid) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5 unexpected result", 128'd1, 128'd0);
        end else begin
          e = sb_q.pop_front();
          chk(out_mask == e.mask, "R3/R4 accumulated masks",
              128'(out_mask[127:0]), 128'(e.mask[127:0]));
          chk(count_est == e.cnt, "R5 count estimate", 128'(count_est), 128'(e.cnt));
          chk(below_threshold == e.below, "R6 below threshold",
              128'(below_threshold), 128'(e.below));
          chk(empty_error == e.err, "R7 empty error", 128'(empty_error), 128'(e.err));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < 16; p++) m_acc[p] = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(out_mask == '1, "R10 reset masks", 128'(out_mask[127:0]), {128{1'b1}});
    chk(!busy && !result_valid && !below_threshold && !empty_error, "R10 reset flags",
        {125'd0, busy, below_threshold, empty_error}, 128'd0);

    // R5 saturation: all candidates survive, count = 16^16 = 2^64
    fill_full();
    send_obs(64'd4096);
    wait_idle();

    // Random observations accumulate (R3, R4)
    fill_rand();
    send_obs(64'd4096);
    wait_idle();
    fill_rand();
    send_obs(64'd65536);
    wait_idle();

    // R1/R2: image 7 is common but position 0 lacks difference 6
    do_clear();
    fill_full();
    for (int p = 0; p < 4; p++) begin
      o_keep[p] = 16'h0003; o_j[p] = 2'(p);
      for (int k = 0; k < 16; k++) o_diff[p][k] = 4'd0;
      o_diff[p][1] = 4'd7;
    end
    o_diff[0][0] = 4'd2; o_diff[1][0] = 4'd1; o_diff[2][0] = 4'd3; o_diff[3][0] = 4'd3;
    o_keep[0] = 16'h0007; o_diff[0][1] = 4'd8; o_diff[0][2] = 4'd7;
    send_obs(64'd4096);
    wait_idle();
    chk(out_mask[15:0] == 16'h0001, "R1 position0 outside common set pruned",
        128'(out_mask[15:0]), 128'h0001);
    chk(out_mask[63:16] == {3{16'h0001}}, "R2 invalid common image pruned",
        128'(out_mask[63:16]), {80'd0, {3{16'h0001}}});

    // R6 strict boundary: count 2^16 against 2^16 and 2^16+1
    do_clear();
    fill_pair();
    send_obs(64'd65536);
    wait_idle();
    do_clear();
    send_obs(64'd65537);
    wait_idle();

    // R7 empty position
    do_clear();
    fill_full();
    o_keep[5] = '0;
    send_obs(64'd4096);
    wait_idle();

    // R9 beat during scan is ignored
    do_clear();
    fill_full();
    send_obs(64'd4096);
    chk(busy == 1'b1, "R9 scan running", 128'(busy), 128'd1);
    grp_valid = 1'b1; grp_idx = 2'd0; grp_keep = '0;
    @(negedge clk);
    grp_valid = 1'b0;
    chk(out_mask == '1, "R9 masks unchanged by busy beat",
        128'(out_mask[127:0]), {128{1'b1}});
    wait_idle();

    // R8 clear beats a simultaneous group
    @(negedge clk);
    clear = 1'b1; grp_valid = 1'b1; grp_idx = 2'd1; grp_keep = '0;
    @(negedge clk);
    clear = 1'b0; grp_valid = 1'b0;
    for (int p = 0; p < 16; p++) m_acc[p] = '1;
    chk(out_mask == '1, "R8 beat dropped under clear",
        128'(out_mask[127:0]), {128{1'b1}});

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule